// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block resolves a virtual page number into a physical page number when the translation cache has no entry for it. It keeps a page table base register, which software rewrites whenever a different process is scheduled. On an accepted translation request it forms the entry address as the base plus four bytes per virtual page number. It issues one read of that 32-bit entry on a simple request/response memory port. When the entry arrives, the block checks it and produces exactly one result pulse.

Each entry carries a valid flag, two access-right flags and the physical page number; it never carries data. An entry whose valid flag is clear yields a page fault. A valid entry that does not permit the requested kind of access yields a protection fault. Any other entry yields its physical page number, which the caller joins to the unchanged page offset and loads into the translation cache. The defaults describe 40-bit virtual addresses, 16 KiB pages (14-bit offset), a 26-bit virtual page number, 64 GiB of physical memory (36-bit physical address) and a 22-bit physical page number. Only one walk is in progress at any time.

Top module: `pt_walker`

## Requirements
- R1: While reset is applied and after it is released, `req_ready` is 1 and `mem_req_valid` and `rsp_valid` are 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the following cycle until the cycle after the result pulse.
- R3: `mem_req_valid` is high for exactly one cycle, in the cycle after acceptance. `mem_req_addr` equals (base + `req_vpn` × 4) modulo 2^36 in that cycle.
- R4: `rsp_valid` is high for exactly one cycle, in the cycle after the cycle in which `mem_rsp_valid` was seen during the walk. `req_ready` returns to 1 in the cycle after that.
- R5: An entry with bit 31 (valid) equal to 0 gives `rsp_status` = 2'b01 (page fault) and `rsp_ppn` = 0, whatever its other bits are.
- R6: A valid entry gives `rsp_status` = 2'b10 (protection fault) and `rsp_ppn` = 0 when the needed right is missing. A read (`req_write` = 0) needs bit 29. A write (`req_write` = 1) needs bit 30.
- R7: A valid entry that grants the needed right gives `rsp_status` = 2'b00 and `rsp_ppn` = entry bits 21:0.
- R8: A base write (`base_we` = 1) is used by every request accepted on a later edge. A base write on the same edge that accepts a request does not change that request's address.
- R9: A base write made while a walk is in progress leaves that walk's address and result unchanged, and takes effect for the next walk.
- R10: `mem_rsp_valid` that arrives while no walk is waiting for data produces no result pulse and leaves `req_ready` at 1.
- R11: `req_valid` while a walk is in progress starts no memory read and is not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| base_we | input | 1 | Write strobe for the page table base |
| base_wdata | input | 36 | New page table base byte address |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Idle and able to accept a request |
| req_vpn | input | 26 | Virtual page number to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| mem_req_valid | output | 1 | One-cycle read strobe for the entry |
| mem_req_addr | output | 36 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_status | output | 2 | 00 translated, 01 page fault, 10 protection fault |
| rsp_ppn | output | 22 | Physical page number, 0 on a fault |

## Verification
The memory read strobe and address are due one cycle after the accepting edge. The result is due one cycle after the edge that sees the entry data, and ready returns one cycle after that. The bench drives inputs on falling edges and samples at the falling edge that follows each of these rising edges. It checks that the strobe stays low in every cycle of a variable memory latency between them. Random walks mix the latency, access type, entry flags and base value. Directed walks place base writes on the accepting edge and in the middle of a walk, and send stray requests and stray memory responses.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_RESP = 2'd3
  } walk_state_t;

  localparam logic [1:0] WALK_OK         = 2'b00;
  localparam logic [1:0] WALK_PAGE_FAULT = 2'b01;
  localparam logic [1:0] WALK_PROT_FAULT = 2'b10;
endpackage

// File: rtl/ptw_rst_sync.sv
module ptw_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int VPN_W     = 26,
  parameter int PA_W      = 36,
  parameter int PTE_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_we,
  input  logic [PA_W-1:0]  base_wdata,
  input  logic             load,
  input  logic [VPN_W-1:0] vpn,
  output logic [PA_W-1:0]  pte_addr
);
  localparam int SH    = $clog2(PTE_BYTES);
  localparam int EXT_W = PA_W - VPN_W - SH;

  logic [PA_W-1:0] base_q, base_d;
  logic [PA_W-1:0] addr_q, addr_d;
  logic [PA_W-1:0] offset;

  assign offset = {{EXT_W{1'b0}}, vpn, {SH{1'b0}}};

  always_comb begin
    base_d = base_q;
    if (base_we) base_d = base_wdata;
    addr_d = addr_q;
    if (load) addr_d = base_q + offset;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      addr_q <= '0;
    end else begin
      base_q <= base_d;
      addr_q <= addr_d;
    end
  end

  assign pte_addr = addr_q;
endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check #(
  parameter int PTE_W     = 32,
  parameter int PPN_W     = 22,
  parameter int VALID_BIT = 31,
  parameter int WR_BIT    = 30,
  parameter int RD_BIT    = 29
) (
  input  logic [PTE_W-1:0] pte,
  input  logic             is_write,
  output logic [1:0]       status,
  output logic [PPN_W-1:0] ppn
);
  import ptw_pkg::*;

  logic right_ok;
  logic unused_pte;

  assign right_ok   = is_write ? pte[WR_BIT] : pte[RD_BIT];
  assign unused_pte = ^pte[RD_BIT-1:PPN_W];

  always_comb begin
    status = WALK_OK;
    ppn    = pte[PPN_W-1:0];
    if (!pte[VALID_BIT]) begin
      status = WALK_PAGE_FAULT;
      ppn    = '0;
    end else if (!right_ok) begin
      status = WALK_PROT_FAULT;
      ppn    = '0;
    end
  end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl #(
  parameter int PPN_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             mem_rsp_valid,
  input  logic [1:0]       chk_status,
  input  logic [PPN_W-1:0] chk_ppn,
  output logic             req_ready,
  output logic             accept,
  output logic             write_q,
  output logic             mem_req_valid,
  output logic             rsp_valid,
  output logic [1:0]       rsp_status,
  output logic [PPN_W-1:0] rsp_ppn
);
  import ptw_pkg::*;

  walk_state_t      state_q, state_d;
  logic             capture;
  logic             write_d;
  logic [1:0]       status_q, status_d;
  logic [PPN_W-1:0] ppn_q, ppn_d;

  assign req_ready     = (state_q == ST_IDLE);
  assign accept        = req_ready && req_valid;
  assign capture       = (state_q == ST_WAIT) && mem_rsp_valid;
  assign mem_req_valid = (state_q == ST_REQ);
  assign rsp_valid     = (state_q == ST_RESP);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept)  state_d = ST_REQ;
      ST_REQ:               state_d = ST_WAIT;
      ST_WAIT: if (capture) state_d = ST_RESP;
      ST_RESP:              state_d = ST_IDLE;
      default:              state_d = ST_IDLE;
    endcase
    write_d  = accept  ? req_write  : write_q;
    status_d = capture ? chk_status : status_q;
    ppn_d    = capture ? chk_ppn    : ppn_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      write_q  <= 1'b0;
      status_q <= WALK_OK;
      ppn_q    <= '0;
    end else begin
      state_q  <= state_d;
      write_q  <= write_d;
      status_q <= status_d;
      ppn_q    <= ppn_d;
    end
  end

  assign rsp_status = status_q;
  assign rsp_ppn    = ppn_q;

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && mem_req_valid));

  p_mem_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  p_fault_no_ppn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != WALK_OK) |-> (rsp_ppn == '0));

  p_stray_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && mem_rsp_valid) |=> !rsp_valid);
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VPN_W     = 26,
  parameter int PPN_W     = 22,
  parameter int PA_W      = 36,
  parameter int PTE_W     = 32,
  parameter int PTE_BYTES = 4,
  parameter int VALID_BIT = 31,
  parameter int WR_BIT    = 30,
  parameter int RD_BIT    = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_we,
  input  logic [PA_W-1:0]  base_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic             req_write,
  output logic             mem_req_valid,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             rsp_valid,
  output logic [1:0]       rsp_status,
  output logic [PPN_W-1:0] rsp_ppn
);
  logic             srst_n;
  logic             accept;
  logic             write_q;
  logic [1:0]       chk_status;
  logic [PPN_W-1:0] chk_ppn;

  ptw_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  ptw_addr_gen #(
    .VPN_W(VPN_W), .PA_W(PA_W), .PTE_BYTES(PTE_BYTES)
  ) u_addr (
    .clk        (clk),
    .rst_n      (srst_n),
    .base_we    (base_we),
    .base_wdata (base_wdata),
    .load       (accept),
    .vpn        (req_vpn),
    .pte_addr   (mem_req_addr)
  );

  ptw_pte_check #(
    .PTE_W(PTE_W), .PPN_W(PPN_W), .VALID_BIT(VALID_BIT),
    .WR_BIT(WR_BIT), .RD_BIT(RD_BIT)
  ) u_check (
    .pte      (mem_rsp_data),
    .is_write (write_q),
    .status   (chk_status),
    .ppn      (chk_ppn)
  );

  ptw_ctrl #(.PPN_W(PPN_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (srst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .mem_rsp_valid (mem_rsp_valid),
    .chk_status    (chk_status),
    .chk_ppn       (chk_ppn),
    .req_ready     (req_ready),
    .accept        (accept),
    .write_q       (write_q),
    .mem_req_valid (mem_req_valid),
    .rsp_valid     (rsp_valid),
    .rsp_status    (rsp_status),
    .rsp_ppn       (rsp_ppn)
  );
endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        base_we = 1'b0;
  logic [35:0] base_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [25:0] req_vpn = '0;
  logic        req_write = 1'b0;
  logic        mem_req_valid;
  logic [35:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [21:0] rsp_ppn;

  int checks = 0;
  int failures = 0;
  logic [35:0] model_base = '0;

  always #4 clk = ~clk;

  pt_walker uut (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
    .req_write(req_write), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid),
    .rsp_status(rsp_status), .rsp_ppn(rsp_ppn)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_status(input logic [31:0] pte, input logic wr);
    if (!pte[31]) return 2'b01;
    if (wr ? !pte[30] : !pte[29]) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [21:0] exp_ppn(input logic [31:0] pte, input logic wr);
    return (exp_status(pte, wr) == 2'b00) ? pte[21:0] : 22'd0;
  endfunction

  function automatic string status_tag(input logic [31:0] pte, input logic wr);
    case (exp_status(pte, wr))
      2'b01:   return "R5";
      2'b10:   return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic walk(input logic [25:0] vpn, input logic wr, input logic [31:0] pte,
                      input int lat, input logic intrude,
                      input logic bw_accept, input logic bw_wait, input logic [35:0] nb);
    logic [35:0] exp_addr;
    exp_addr = model_base + {8'd0, vpn, 2'b00};
    @(negedge clk);
    check("R2 ready before request", req_ready, 1);
    req_valid = 1'b1; req_vpn = vpn; req_write = wr;
    if (bw_accept) begin base_we = 1'b1; base_wdata = nb; end
    @(negedge clk);
    req_valid = 1'b0; req_write = ~wr; base_we = 1'b0;
    if (bw_accept) model_base = nb;
    check("R3 mem request strobe", mem_req_valid, 1);
    check(bw_accept ? "R8 address uses old base" : "R3 entry address", mem_req_addr, exp_addr);
    check("R2 busy after accept", req_ready, 0);
    if (intrude) begin req_valid = 1'b1; req_vpn = ~vpn; end
    for (int i = 0; i <= lat; i++) begin
      if (bw_wait && i == 0) begin base_we = 1'b1; base_wdata = nb; end
      @(negedge clk);
      if (bw_wait && i == 0) begin base_we = 1'b0; model_base = nb; end
      check(intrude ? "R11 no read while busy" : "R3 single strobe", mem_req_valid, 0);
      check("R4 no early result", rsp_valid, 0);
    end
    mem_rsp_valid = 1'b1; mem_rsp_data = pte;
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_data = $urandom; req_valid = 1'b0;
    check("R4 result strobe", rsp_valid, 1);
    check(status_tag(pte, wr), rsp_status, exp_status(pte, wr));
    check(bw_wait ? "R9 result unchanged" : status_tag(pte, wr), rsp_ppn, exp_ppn(pte, wr));
    check("R4 busy during result", req_ready, 0);
    @(negedge clk);
    check("R4 single result strobe", rsp_valid, 0);
    check("R4 ready after result", req_ready, 1);
    check("R11 stray request not queued", mem_req_valid, 0);
  endtask

  task automatic write_base(input logic [35:0] nb);
    @(negedge clk);
    base_we = 1'b1; base_wdata = nb;
    @(negedge clk);
    base_we = 1'b0;
    model_base = nb;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0061));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", req_ready, 1);
    check("R1 no read in reset", mem_req_valid, 0);
    check("R1 no result in reset", rsp_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 ready after reset", req_ready, 1);
    check("R1 idle result after reset", rsp_valid, 0);

    // R7 read allowed, zero base
    walk(26'h0000123, 1'b0, 32'hA000_1ABC, 0, 1'b0, 1'b0, 1'b0, '0);
    // R7 write allowed, top VPN
    walk(26'h3FF_FFFF, 1'b1, 32'hC03F_FFFF, 2, 1'b0, 1'b0, 1'b0, '0);
    // R5 invalid entry with all rights
    walk(26'h0000010, 1'b0, 32'h7FFF_FFFF, 1, 1'b0, 1'b0, 1'b0, '0);
    // R6 write to read-only, read to write-only
    walk(26'h0000011, 1'b1, 32'hA012_3456, 0, 1'b0, 1'b0, 1'b0, '0);
    walk(26'h0000012, 1'b0, 32'hC012_3456, 3, 1'b0, 1'b0, 1'b0, '0);
    // R8 base write, then next walk uses it; address wraps modulo 2^36
    write_base(36'hF_FFFF_FF00);
    walk(26'h0000100, 1'b0, 32'hE000_0001, 0, 1'b0, 1'b0, 1'b0, '0);
    // R8 base write on the accepting edge
    walk(26'h0000042, 1'b1, 32'hE000_0002, 1, 1'b0, 1'b1, 1'b0, 36'h0_1000_0000);
    walk(26'h0000043, 1'b1, 32'hE000_0003, 0, 1'b0, 1'b0, 1'b0, '0);
    // R9 base write during walk
    walk(26'h0000044, 1'b0, 32'hA000_0044, 2, 1'b0, 1'b0, 1'b1, 36'h2_0000_4000);
    walk(26'h0000045, 1'b0, 32'hA000_0045, 0, 1'b0, 1'b0, 1'b0, '0);
    // R11 request held during walk
    walk(26'h0000046, 1'b0, 32'hA000_0046, 3, 1'b1, 1'b0, 1'b0, '0);
    // R10 stray memory response while idle
    @(negedge clk);
    mem_rsp_valid = 1'b1; mem_rsp_data = 32'hE000_0BAD;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    check("R10 no result from stray data", rsp_valid, 0);
    check("R10 still ready", req_ready, 1);
    @(negedge clk);
    check("R10 no late result", rsp_valid, 0);

    for (int n = 0; n < 60; n++) begin
      logic [31:0] r;
      logic [31:0] pte;
      r = $urandom;
      pte = $urandom;
      if (r[3:0] == 4'd0) write_base({r[31:28], $urandom});
      walk(26'($urandom), r[4], pte, int'(r[7:5]), r[8],
           (r[11:9] == 3'd0), (r[14:12] == 3'd0), {r[27:24], $urandom});
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule